// File: doc/BRIEF.md
# Descriptor Ring Controller

This block owns the buffer descriptor table of a DMA network interface and decides, descriptor by descriptor, when the transmit side may launch a frame and when the receive side may take one in. A single table of 128 descriptors is shared by both directions. A programmable split point divides it: transmit uses the slots below the split point and receive uses the slots from the split point up to the last slot. Each direction keeps its own current slot and its own wrap rules.

Every descriptor has two 32-bit words. The control word carries a 16-bit length in bits 31:16 and flags below it. The pointer word carries the buffer address. The data mover outside this block reports each finished frame with a done pulse, and for receive it also gives the frame length. The controller then updates the descriptor flags, steps its slot, and sets an interrupt source bit when the descriptor asks for one. A source register and a mask register drive one interrupt line.

Top module: `dring_ctrl`

## Requirements
- R1: After reset the mode register reads 0, the source and mask registers read 0, the split point reads 0x40, the transmit slot is 0, the receive slot is 0x40, and `irq`, `tx_start` and `rx_ready` are low. The register port decodes `cfg_addr` as 0 = mode (bit 0 transmit enable, bit 1 receive enable), 1 = interrupt source, 2 = interrupt mask, 3 = split point. On the descriptor port, word address 2*slot addresses the control word and 2*slot+1 addresses the pointer word.
- R2: `tx_start` can be high only while no transmit is outstanding, transmit is enabled, the split point is non-zero, control bit 15 (ready) of the current transmit descriptor is set and its length field is greater than 4. A length of exactly 4 does not start a transmit.
- R3: In the cycle `tx_start` is high, `tx_buf_ptr` and `tx_frame_len` show the pointer word and the length field of the current transmit descriptor. No further start occurs until a `tx_done` pulse ends the outstanding transmit.
- R4: When a transmit completes, the transmit slot becomes 0 if control bit 13 (wrap) is set. Otherwise the slot increments, and it becomes 0 when the incremented value is equal to or above the split point.
- R5: When a transmit completes, control bits 15 and 8:0 of that descriptor are cleared and all other bits are kept.
- R6: `rx_ready` is high only when receive is enabled, the split point is below 128 and control bit 15 (empty) of the current receive descriptor is set.
- R7: When `rx_done` arrives while `rx_ready` is high, the descriptor's length field takes `rx_len`, bit 15 is cleared and bits 14:0 are kept. The receive slot then returns to the split point if bit 13 (wrap) was set or the slot was 127. Otherwise it increments.
- R8: A completed descriptor with control bit 14 set sets source bit 0 for transmit and source bit 2 for receive. When both directions complete in the same cycle, both bits are set.
- R9: Writing the source register clears each bit written as 1. `irq` is high exactly when some source bit and its mask bit are both set.
- R10: A 0-to-1 change of receive enable loads the receive slot from the split point. A 0-to-1 change of transmit enable sets the transmit slot to 0, and the start condition is then tested again.
- R11: A host write to the descriptor table that makes the current transmit descriptor eligible starts a transmit in the following cycle.
- R12: A `tx_done` with no transmit outstanding, or an `rx_done` while `rx_ready` is low, changes neither slot, no descriptor and no source bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| dsc_we | input | 1 | Descriptor table write strobe |
| dsc_addr | input | 8 | Descriptor word address |
| dsc_wdata | input | 32 | Descriptor write data |
| dsc_rdata | output | 32 | Descriptor word at `dsc_addr` |
| tx_start | output | 1 | Launch the transmit described by the current slot |
| tx_buf_ptr | output | 32 | Buffer address of the current transmit descriptor |
| tx_frame_len | output | 16 | Length field of the current transmit descriptor |
| tx_done | input | 1 | Outstanding transmit has finished |
| tx_slot | output | 7 | Current transmit slot |
| rx_ready | output | 1 | A receive frame can be accepted now |
| rx_buf_ptr | output | 32 | Buffer address of the current receive descriptor |
| rx_done | input | 1 | A receive frame has finished |
| rx_len | input | 16 | Length of the finished receive frame |
| rx_slot | output | 7 | Current receive slot |
| irq | output | 1 | Interrupt line |

## Verification
Register and descriptor writes take effect at the capturing edge, so read-back, `rx_ready` and `tx_start` are checked at the falling edge of the next cycle, with no extra delay. Slot steps, flag updates and source bits follow a done pulse by one edge and are checked at the falling edge after that. `irq` follows source and mask in the same cycle. Every expected launch, with its pointer and length, is queued before the write that causes it. A monitor checks each `tx_start` it sees against the head of the queue, so a start that is early, late, spurious or missing is reported.

// File: rtl/dring_pkg.sv
// Shared constants and types for the descriptor ring controller.
// Assumes the control word layout: length in 31:16, flags below.
package dring_pkg;
    localparam int DATA_W     = 32;
    localparam int LEN_W      = 16;
    localparam int LEN_LSB    = 16;
    localparam int BIT_OWN    = 15;   // ready (transmit) / empty (receive)
    localparam int BIT_IRQ    = 14;
    localparam int BIT_WRAP   = 13;
    localparam logic [DATA_W-1:0] TX_CLR_MASK = 32'h0000_81FF;
    localparam int MIN_TX_LEN = 4;
    localparam int SRC_W      = 3;
    localparam int SRC_TX     = 0;
    localparam int SRC_RX     = 2;
    localparam int MODE_TX    = 0;
    localparam int MODE_RX    = 1;

    typedef enum logic [1:0] {
        CFG_MODE  = 2'd0,
        CFG_SRC   = 2'd1,
        CFG_MASK  = 2'd2,
        CFG_BOUND = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_BUSY = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] ctl;
    } ctl_upd_t;
endpackage

// File: rtl/dring_table.sv
// Descriptor storage: control and pointer word per slot.
// Three read ports (host, transmit slot, receive slot), combinational.
// Write priority: host first, then receive update, then transmit update,
// so an engine update overrides a host write to the same control word.
module dring_table
    import dring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int IDX_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IDX_W:0]    host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  tx_idx,
    output logic [DATA_W-1:0] tx_ctl,
    output logic [DATA_W-1:0] tx_ptr,
    input  ctl_upd_t          tx_upd,
    input  logic [IDX_W-1:0]  rx_idx,
    output logic [DATA_W-1:0] rx_ctl,
    output logic [DATA_W-1:0] rx_ptr,
    input  ctl_upd_t          rx_upd
);
    logic [DATA_W-1:0] ctl_q [NUM_DESC];
    logic [DATA_W-1:0] ptr_q [NUM_DESC];
    logic [IDX_W-1:0]  host_slot;

    assign host_slot = host_addr[IDX_W:1];

    // Store host writes and engine flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DESC; i++) begin
                ctl_q[i] <= '0;
                ptr_q[i] <= '0;
            end
        end else begin
            if (host_we) begin
                if (host_addr[0]) begin
                    ptr_q[host_slot] <= host_wdata;
                end else begin
                    ctl_q[host_slot] <= host_wdata;
                end
            end
            if (rx_upd.en) begin
                ctl_q[rx_idx] <= rx_upd.ctl;
            end
            if (tx_upd.en) begin
                ctl_q[tx_idx] <= tx_upd.ctl;
            end
        end
    end

    // Read ports.
    always_comb begin
        host_rdata = host_addr[0] ? ptr_q[host_slot] : ctl_q[host_slot];
        tx_ctl     = ctl_q[tx_idx];
        tx_ptr     = ptr_q[tx_idx];
        rx_ctl     = ctl_q[rx_idx];
        rx_ptr     = ptr_q[rx_idx];
    end
endmodule

// File: rtl/dring_tx_seq.sv
// Transmit sequencer: tests the launch condition of the current slot,
// holds one outstanding transmit, and on completion clears the ready
// and status flags and steps the slot (wrap flag or split point).
module dring_tx_seq
    import dring_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int BOUND_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               tx_en_rise,
    input  logic [BOUND_W-1:0] bound,
    input  logic [DATA_W-1:0]  cur_ctl,
    input  logic               tx_done,
    output logic               tx_start,
    output logic [IDX_W-1:0]   slot,
    output ctl_upd_t           upd,
    output logic               irq_evt
);
    tx_state_e          state_q;
    logic [IDX_W-1:0]   slot_q;
    logic [IDX_W-1:0]   slot_nxt;
    logic [BOUND_W-1:0] slot_inc;
    logic               go;
    logic               finish;

    assign go = (state_q == TX_IDLE) && tx_en && (bound != '0)
              && cur_ctl[BIT_OWN]
              && (cur_ctl[LEN_LSB +: LEN_W] > LEN_W'(MIN_TX_LEN));
    assign finish   = (state_q == TX_BUSY) && tx_done;
    assign slot_inc = BOUND_W'(slot_q) + BOUND_W'(1);

    // Next slot after a completed transmit.
    always_comb begin
        if (cur_ctl[BIT_WRAP]) begin
            slot_nxt = '0;
        end else if (slot_inc >= bound) begin
            slot_nxt = '0;
        end else begin
            slot_nxt = slot_inc[IDX_W-1:0];
        end
    end

    // Track the outstanding transmit and the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            slot_q  <= '0;
        end else begin
            if (go) begin
                state_q <= TX_BUSY;
            end else if (finish) begin
                state_q <= TX_IDLE;
            end
            if (tx_en_rise) begin
                slot_q <= '0;
            end else if (finish) begin
                slot_q <= slot_nxt;
            end
        end
    end

    // Completion write-back and interrupt event.
    always_comb begin
        upd.en   = finish;
        upd.ctl  = cur_ctl & ~TX_CLR_MASK;
        irq_evt  = finish && cur_ctl[BIT_IRQ];
        tx_start = go;
        slot     = slot_q;
    end
endmodule

// File: rtl/dring_rx_seq.sv
// Receive sequencer: signals when the current slot can take a frame,
// writes the length and clears the empty flag on completion, and steps
// the slot (wrap flag or last slot returns to the split point).
module dring_rx_seq
    import dring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int IDX_W    = 7,
    parameter int BOUND_W  = 8,
    parameter int RST_SLOT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               rx_en_rise,
    input  logic [BOUND_W-1:0] bound,
    input  logic [DATA_W-1:0]  cur_ctl,
    input  logic               rx_done,
    input  logic [LEN_W-1:0]   rx_len,
    output logic               rx_ready,
    output logic [IDX_W-1:0]   slot,
    output ctl_upd_t           upd,
    output logic               irq_evt
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_DESC - 1);

    logic [IDX_W-1:0] slot_q;
    logic [IDX_W-1:0] slot_nxt;
    logic             ready;
    logic             accept;

    assign ready  = rx_en && (bound < BOUND_W'(NUM_DESC)) && cur_ctl[BIT_OWN];
    assign accept = ready && rx_done;

    // Next slot after an accepted frame.
    always_comb begin
        if (cur_ctl[BIT_WRAP] || (slot_q == LAST_SLOT)) begin
            slot_nxt = bound[IDX_W-1:0];
        end else begin
            slot_nxt = slot_q + IDX_W'(1);
        end
    end

    // Current receive slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= IDX_W'(RST_SLOT);
        end else if (rx_en_rise) begin
            slot_q <= bound[IDX_W-1:0];
        end else if (accept) begin
            slot_q <= slot_nxt;
        end
    end

    // Completion write-back and interrupt event.
    always_comb begin
        upd.en                      = accept;
        upd.ctl                     = cur_ctl;
        upd.ctl[BIT_OWN]            = 1'b0;
        upd.ctl[LEN_LSB +: LEN_W]   = rx_len;
        irq_evt                     = accept && cur_ctl[BIT_IRQ];
        rx_ready                    = ready;
        slot                        = slot_q;
    end
endmodule

// File: rtl/dring_irq.sv
// Interrupt source and mask registers. Events set source bits;
// host writes clear the bits written as 1, events win a same-cycle
// clash. The line is the OR of source AND mask.
module dring_irq
    import dring_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_we,
    input  logic             mask_we,
    input  logic [SRC_W-1:0] wdata,
    input  logic             tx_evt,
    input  logic             rx_evt,
    output logic [SRC_W-1:0] src,
    output logic [SRC_W-1:0] mask,
    output logic             irq
);
    logic [SRC_W-1:0] src_q;
    logic [SRC_W-1:0] mask_q;
    logic [SRC_W-1:0] evt;
    logic [SRC_W-1:0] clr;
    logic [SRC_W-1:0] src_nxt;

    // Map engine events onto source bit positions.
    always_comb begin
        evt         = '0;
        evt[SRC_TX] = tx_evt;
        evt[SRC_RX] = rx_evt;
    end

    assign clr = src_we ? wdata : '0;

    for (genvar g = 0; g < SRC_W; g++) begin : g_src
        assign src_nxt[g] = evt[g] | (src_q[g] & ~clr[g]);
    end

    // Source and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            mask_q <= '0;
        end else begin
            src_q <= src_nxt;
            if (mask_we) begin
                mask_q <= wdata;
            end
        end
    end

    assign src  = src_q;
    assign mask = mask_q;
    assign irq  = |(src_q & mask_q);
endmodule

// File: rtl/dring_ctrl.sv
// Descriptor ring controller top: mode and split-point registers,
// enable edge detection, and the table, sequencers and interrupt unit.
// Assumes NUM_DESC is a power of two.
module dring_ctrl
    import dring_pkg::*;
#(
    parameter int NUM_DESC = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        dsc_we,
    input  logic [$clog2(NUM_DESC):0]   dsc_addr,
    input  logic [31:0] dsc_wdata,
    output logic [31:0] dsc_rdata,
    output logic        tx_start,
    output logic [31:0] tx_buf_ptr,
    output logic [15:0] tx_frame_len,
    input  logic        tx_done,
    output logic [$clog2(NUM_DESC)-1:0] tx_slot,
    output logic        rx_ready,
    output logic [31:0] rx_buf_ptr,
    input  logic        rx_done,
    input  logic [15:0] rx_len,
    output logic [$clog2(NUM_DESC)-1:0] rx_slot,
    output logic        irq
);
    localparam int IDX_W     = $clog2(NUM_DESC);
    localparam int BOUND_W   = IDX_W + 1;
    localparam int BOUND_RST = NUM_DESC / 2;

    logic [1:0]         mode_q;
    logic [BOUND_W-1:0] bound_q;
    logic               mode_we;
    logic               tx_rise;
    logic               rx_rise;
    logic [DATA_W-1:0]  tx_ctl;
    logic [DATA_W-1:0]  rx_ctl;
    ctl_upd_t           tx_upd;
    ctl_upd_t           rx_upd;
    logic               tx_evt;
    logic               rx_evt;
    logic [SRC_W-1:0]   int_src;
    logic [SRC_W-1:0]   int_mask;
    cfg_sel_e           sel;

    assign sel     = cfg_sel_e'(cfg_addr);
    assign mode_we = cfg_we && (sel == CFG_MODE);
    assign tx_rise = mode_we && cfg_wdata[MODE_TX] && !mode_q[MODE_TX];
    assign rx_rise = mode_we && cfg_wdata[MODE_RX] && !mode_q[MODE_RX];

    // Mode and split-point registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            bound_q <= BOUND_W'(BOUND_RST);
        end else if (cfg_we) begin
            if (sel == CFG_MODE) begin
                mode_q <= cfg_wdata[1:0];
            end
            if (sel == CFG_BOUND) begin
                bound_q <= cfg_wdata[BOUND_W-1:0];
            end
        end
    end

    // Register read mux.
    always_comb begin
        cfg_rdata = '0;
        case (sel)
            CFG_MODE:  cfg_rdata[1:0]         = mode_q;
            CFG_SRC:   cfg_rdata[SRC_W-1:0]   = int_src;
            CFG_MASK:  cfg_rdata[SRC_W-1:0]   = int_mask;
            default:   cfg_rdata[BOUND_W-1:0] = bound_q;
        endcase
    end

    dring_table #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (dsc_we),
        .host_addr  (dsc_addr),
        .host_wdata (dsc_wdata),
        .host_rdata (dsc_rdata),
        .tx_idx     (tx_slot),
        .tx_ctl     (tx_ctl),
        .tx_ptr     (tx_buf_ptr),
        .tx_upd     (tx_upd),
        .rx_idx     (rx_slot),
        .rx_ctl     (rx_ctl),
        .rx_ptr     (rx_buf_ptr),
        .rx_upd     (rx_upd)
    );

    dring_tx_seq #(
        .IDX_W   (IDX_W),
        .BOUND_W (BOUND_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (mode_q[MODE_TX]),
        .tx_en_rise (tx_rise),
        .bound      (bound_q),
        .cur_ctl    (tx_ctl),
        .tx_done    (tx_done),
        .tx_start   (tx_start),
        .slot       (tx_slot),
        .upd        (tx_upd),
        .irq_evt    (tx_evt)
    );

    dring_rx_seq #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W),
        .BOUND_W  (BOUND_W),
        .RST_SLOT (BOUND_RST)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (mode_q[MODE_RX]),
        .rx_en_rise (rx_rise),
        .bound      (bound_q),
        .cur_ctl    (rx_ctl),
        .rx_done    (rx_done),
        .rx_len     (rx_len),
        .rx_ready   (rx_ready),
        .slot       (rx_slot),
        .upd        (rx_upd),
        .irq_evt    (rx_evt)
    );

    dring_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_we  (cfg_we && (sel == CFG_SRC)),
        .mask_we (cfg_we && (sel == CFG_MASK)),
        .wdata   (cfg_wdata[SRC_W-1:0]),
        .tx_evt  (tx_evt),
        .rx_evt  (rx_evt),
        .src     (int_src),
        .mask    (int_mask),
        .irq     (irq)
    );

    assign tx_frame_len = tx_ctl[LEN_LSB +: LEN_W];
endmodule

// File: rtl/dring_ctrl_chk.sv
// Property checker for dring_ctrl, attached by bind below.
module dring_ctrl_chk
    import dring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int IDX_W    = 7,
    parameter int BOUND_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_start,
    input logic [IDX_W-1:0]   tx_slot,
    input logic               rx_ready,
    input logic               rx_done,
    input logic [IDX_W-1:0]   rx_slot,
    input logic [DATA_W-1:0]  rx_ctl,
    input logic               rx_rise,
    input logic [1:0]         mode_q,
    input logic [BOUND_W-1:0] bound_q,
    input logic [SRC_W-1:0]   int_src,
    input logic [SRC_W-1:0]   int_mask,
    input logic               irq
);
    assert_tx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (mode_q[MODE_TX] && (bound_q != '0)));

    assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    assert_tx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_slot) |-> ((tx_slot == '0) || (tx_slot == $past(tx_slot) + IDX_W'(1))));

    assert_rx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (mode_q[MODE_RX] && (bound_q < BOUND_W'(NUM_DESC))));

    assert_rx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rx_done && !rx_ctl[BIT_WRAP] && !rx_rise
         && (rx_slot != IDX_W'(NUM_DESC - 1)))
        |=> (rx_slot == $past(rx_slot) + IDX_W'(1)));

    assert_rx_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rx_done && rx_ctl[BIT_IRQ]) |=> int_src[SRC_RX]);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_src & int_mask) == '0) |-> !irq);

    assert_rx_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rise |=> (rx_slot == $past(bound_q[IDX_W-1:0])));
endmodule

bind dring_ctrl dring_ctrl_chk #(
    .NUM_DESC (NUM_DESC),
    .IDX_W    (IDX_W),
    .BOUND_W  (BOUND_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_start (tx_start),
    .tx_slot  (tx_slot),
    .rx_ready (rx_ready),
    .rx_done  (rx_done),
    .rx_slot  (rx_slot),
    .rx_ctl   (rx_ctl),
    .rx_rise  (rx_rise),
    .mode_q   (mode_q),
    .bound_q  (bound_q),
    .int_src  (int_src),
    .int_mask (int_mask),
    .irq      (irq)
);

// File: tb/dring_ctrl_tb.sv
// Scoreboard bench: the sequence queues each expected launch; a monitor
// compares every tx_start against the queue head.
module dring_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dsc_we = 1'b0;
    logic [7:0]  dsc_addr = '0;
    logic [31:0] dsc_wdata = '0;
    logic [31:0] dsc_rdata;
    logic        tx_start;
    logic [31:0] tx_buf_ptr;
    logic [15:0] tx_frame_len;
    logic        tx_done = 1'b0;
    logic [6:0]  tx_slot;
    logic        rx_ready;
    logic [31:0] rx_buf_ptr;
    logic        rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic [6:0]  rx_slot;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [47:0] exp_q[$];

    always #10 clk = ~clk;

    dring_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dsc_we(dsc_we), .dsc_addr(dsc_addr), .dsc_wdata(dsc_wdata), .dsc_rdata(dsc_rdata),
        .tx_start(tx_start), .tx_buf_ptr(tx_buf_ptr), .tx_frame_len(tx_frame_len),
        .tx_done(tx_done), .tx_slot(tx_slot),
        .rx_ready(rx_ready), .rx_buf_ptr(rx_buf_ptr), .rx_done(rx_done), .rx_len(rx_len),
        .rx_slot(rx_slot), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        cfg_addr = a;
        @(negedge clk);
        d = cfg_rdata;
    endtask

    task automatic dsc_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        dsc_we = 1'b1; dsc_addr = a; dsc_wdata = d;
        @(posedge clk); #2;
        dsc_we = 1'b0;
    endtask

    task automatic dsc_read(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        dsc_addr = a;
        @(negedge clk);
        d = dsc_rdata;
    endtask

    task automatic pulse_done(input bit t, input bit r, input logic [15:0] len);
        @(posedge clk); #2;
        tx_done = t; rx_done = r; rx_len = len;
        @(posedge clk); #2;
        tx_done = 1'b0; rx_done = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_start(input logic [31:0] ptr, input logic [15:0] len);
        exp_q.push_back({ptr, len});
    endtask

    task automatic drained(input string req);
        idle(2);
        check(req, 32'(exp_q.size()), 32'd0);
    endtask

    // Monitor: each launch must match the queued pointer and length (R3).
    always @(negedge clk) begin
        if (rst_n && tx_start === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R2 unexpected launch: actual ptr 0x%08h len %0d expected none",
                         tx_buf_ptr, tx_frame_len);
            end else begin
                logic [47:0] e;
                e = exp_q.pop_front();
                check("R3 launch pointer", tx_buf_ptr, e[47:16]);
                check("R3 launch length", {16'h0, tx_frame_len}, {16'h0, e[15:0]});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        cfg_read(2'd0, d); check("R1 mode", d, 32'h0);
        cfg_read(2'd1, d); check("R1 source", d, 32'h0);
        cfg_read(2'd2, d); check("R1 mask", d, 32'h0);
        cfg_read(2'd3, d); check("R1 split point", d, 32'h40);
        check("R1 tx slot", 32'(tx_slot), 32'h0);
        check("R1 rx slot", 32'(rx_slot), 32'h40);
        check("R1 irq/start/ready", {29'h0, irq, tx_start, rx_ready}, 32'h0);

        // R2: length 4 never launches
        dsc_write(8'd1, 32'h0000_1000);
        dsc_write(8'd0, 32'h0004_8000);
        cfg_write(2'd0, 32'h1);
        idle(3);
        check("R2 slot held at length 4", 32'(tx_slot), 32'h0);
        // R2: disabled transmit never launches
        cfg_write(2'd0, 32'h0);
        dsc_write(8'd0, 32'h0005_D3FF);
        idle(3);
        // R10: enable edge re-tests the launch condition
        expect_start(32'h0000_1000, 16'd5);
        cfg_write(2'd0, 32'h1);
        drained("R10 launch on enable edge");
        pulse_done(1'b1, 1'b0, 16'h0);
        @(negedge clk);
        check("R4 slot increments", 32'(tx_slot), 32'h1);
        dsc_read(8'd0, d); check("R5 flags cleared", d, 32'h0005_5200);
        cfg_read(2'd1, d); check("R8 tx source bit", d, 32'h1);
        check("R9 masked off", {31'h0, irq}, 32'h0);
        cfg_write(2'd2, 32'h1);
        check("R9 irq with mask", {31'h0, irq}, 32'h1);
        cfg_write(2'd1, 32'h1);
        cfg_read(2'd1, d); check("R9 write one clears", d, 32'h0);
        check("R9 irq drops", {31'h0, irq}, 32'h0);

        // R4: wrap flag returns to slot 0; R11: descriptor write launches
        dsc_write(8'd3, 32'h0000_2000);
        expect_start(32'h0000_2000, 16'd8);
        dsc_write(8'd2, 32'h0008_A000);
        drained("R11 launch on descriptor write");
        pulse_done(1'b1, 1'b0, 16'h0);
        @(negedge clk);
        check("R4 wrap flag", 32'(tx_slot), 32'h0);
        dsc_read(8'd2, d); check("R5 wrap kept", d, 32'h0008_2000);

        // R4: split point wrap
        cfg_write(2'd3, 32'h2);
        dsc_write(8'd1, 32'h0000_3000);
        expect_start(32'h0000_3000, 16'd6);
        dsc_write(8'd0, 32'h0006_8000);
        drained("R11 launch slot 0");
        pulse_done(1'b1, 1'b0, 16'h0);
        dsc_write(8'd3, 32'h0000_3100);
        expect_start(32'h0000_3100, 16'd7);
        dsc_write(8'd2, 32'h0007_8000);
        drained("R11 launch slot 1");
        pulse_done(1'b1, 1'b0, 16'h0);
        @(negedge clk);
        check("R4 split point wrap", 32'(tx_slot), 32'h0);

        // R2: split point zero blocks launch
        cfg_write(2'd3, 32'h0);
        dsc_write(8'd1, 32'h0000_3200);
        dsc_write(8'd0, 32'h0009_8000);
        idle(3);
        expect_start(32'h0000_3200, 16'd9);
        cfg_write(2'd3, 32'h2);
        drained("R2 launch after split point restored");
        pulse_done(1'b1, 1'b0, 16'h0);
        @(negedge clk);
        check("R4 step after restore", 32'(tx_slot), 32'h1);

        // R12: stray transmit done
        pulse_done(1'b1, 1'b0, 16'h0);
        @(negedge clk);
        check("R12 stray tx done", 32'(tx_slot), 32'h1);

        // R10 / R6: receive enable edge
        cfg_write(2'd3, 32'd126);
        cfg_write(2'd0, 32'h3);
        check("R10 rx slot reload", 32'(rx_slot), 32'd126);
        check("R6 not empty", {31'h0, rx_ready}, 32'h0);
        dsc_write(8'd253, 32'h0000_5000);
        dsc_write(8'd252, 32'hABCD_C030);
        check("R6 ready", {31'h0, rx_ready}, 32'h1);
        check("R6 rx pointer", rx_buf_ptr, 32'h0000_5000);
        pulse_done(1'b0, 1'b1, 16'h0040);
        @(negedge clk);
        check("R7 increment", 32'(rx_slot), 32'd127);
        dsc_read(8'd252, d); check("R7 length written", d, 32'h0040_4030);
        cfg_read(2'd1, d); check("R8 rx source bit", d, 32'h4);
        dsc_write(8'd254, 32'h0000_8000);
        pulse_done(1'b0, 1'b1, 16'h003C);
        @(negedge clk);
        check("R7 last slot returns", 32'(rx_slot), 32'd126);
        dsc_read(8'd254, d); check("R7 last slot flags", d, 32'h003C_0000);
        pulse_done(1'b0, 1'b1, 16'h0099);
        @(negedge clk);
        check("R12 rx done ignored slot", 32'(rx_slot), 32'd126);
        dsc_read(8'd252, d); check("R12 rx done ignored desc", d, 32'h0040_4030);

        // R6: split point 128 blocks receive
        cfg_write(2'd3, 32'h80);
        dsc_write(8'd252, 32'h0000_8000);
        check("R6 split point 128", {31'h0, rx_ready}, 32'h0);
        cfg_write(2'd3, 32'h7C);
        dsc_write(8'd252, 32'h0000_A000);
        pulse_done(1'b0, 1'b1, 16'h0010);
        @(negedge clk);
        check("R7 wrap to split point", 32'(rx_slot), 32'd124);
        dsc_read(8'd252, d); check("R7 wrap flags", d, 32'h0010_2000);

        // R6: receive disabled
        cfg_write(2'd0, 32'h1);
        dsc_write(8'd248, 32'h0000_8000);
        check("R6 disabled", {31'h0, rx_ready}, 32'h0);
        cfg_write(2'd3, 32'h7D);
        cfg_write(2'd0, 32'h3);
        check("R10 reload new split point", 32'(rx_slot), 32'd125);

        // R8: both completions in one cycle
        cfg_write(2'd1, 32'h4);
        dsc_write(8'd3, 32'h0000_6000);
        expect_start(32'h0000_6000, 16'd10);
        dsc_write(8'd2, 32'h000A_C000);
        drained("R11 launch slot 1 again");
        dsc_write(8'd250, 32'h0000_C000);
        pulse_done(1'b1, 1'b1, 16'h0020);
        @(negedge clk);
        cfg_read(2'd1, d); check("R8 both source bits", d, 32'h5);
        check("R4 tx step", 32'(tx_slot), 32'h2);
        check("R7 rx step", 32'(rx_slot), 32'd126);
        check("R9 irq mask 1", {31'h0, irq}, 32'h1);
        cfg_write(2'd2, 32'h0);
        check("R9 irq mask 0", {31'h0, irq}, 32'h0);
        cfg_write(2'd2, 32'h4);
        check("R9 irq mask 4", {31'h0, irq}, 32'h1);
        cfg_write(2'd1, 32'h4);
        cfg_read(2'd1, d); check("R9 partial clear", d, 32'h1);
        check("R9 irq after clear", {31'h0, irq}, 32'h0);

        idle(2);
        check("R3 no launch left pending", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule